// File: doc/BRIEF.md
# Dual-Edge Dithered Combine PWM

This block produces one pulse-width-modulated signal and its complement from a pair of compare channels that share a free-running up-counter. The counter runs from a programmable start value up to a programmable modulus, then reloads the start value. The output turns active when the counter reaches the first channel's compare value. It turns inactive when the counter reaches the second channel's compare value.

Each channel also has a 5-bit fractional input and its own 5-bit phase accumulator. At the end of every period, the fractional value is added to the accumulator. A carry out of bit 4 delays that channel's edge by one counter tick for the whole of the next period. Over 32 periods this makes the average pulse width exact to 1/32 of a tick.

The block is meant to sit behind a register block that holds its configuration stable between resets.

Top module: `pwm_dither_pair`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the output is in its inactive level: pwm_o=0 and pwm_n_o=1 when pol_sel_i=2'b10. Both accumulators and both overflow flags are zero.
- R2: The counter steps by one on each clock. In the cycle after it equals mod_i it holds start_i, so a period lasts mod_i-start_i+1 clocks. With both fractional inputs zero, rising edges of the active level are exactly that many clocks apart.
- R3: With both fractional inputs zero, every pulse lasts cmp_clr_i-cmp_set_i clocks. The active level begins one clock after the counter equals cmp_set_i.
- R4: At each period end a channel's accumulator becomes (acc+frac) mod 32. The overflow flag becomes 1 exactly when acc+frac is 32 or more. With start 0, modulus 6, compares 2 and 4, and frac_set_i=3, the first overflow occurs at the end of period 11.
- R5: In a period that follows an overflow of the set channel, the active edge is taken at cmp_set_i+1, so that pulse is one clock shorter (width 1 in the R4 case, 12th pulse).
- R6: In a period that follows an overflow of the clear channel, the inactive edge is taken at cmp_clr_i+1, so that pulse is one clock longer (width 3 in the R4 case with frac_clr_i=3, 12th pulse).
- R7: Overflow flags and accumulators change only at a period end, so no edge position moves within a period. The output matches a cycle-accurate model on every clock.
- R8: Over the 32 pulses that follow the first, the total active time equals 32*(cmp_clr_i-cmp_set_i)+frac_clr_i-frac_set_i clocks.
- R9: pol_sel_i=2'b10 selects a high-true pulse. Any other value inverts pwm_o, so its inactive level is 1.
- R10: pwm_n_o is the complement of pwm_o on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | CNT_W | Counter reload value |
| mod_i | input | CNT_W | Last counter value of a period |
| cmp_set_i | input | CNT_W | Compare value that starts the pulse |
| cmp_clr_i | input | CNT_W | Compare value that ends the pulse |
| frac_set_i | input | 5 | Fractional step for the set channel |
| frac_clr_i | input | 5 | Fractional step for the clear channel |
| pol_sel_i | input | 2 | Polarity select, 2'b10 = high-true |
| pwm_o | output | 1 | Combined PWM output |
| pwm_n_o | output | 1 | Complement of pwm_o |

## Verification
The hardest situation to reach is a dithered edge. It needs the accumulator to wrap, and with small fractional values that happens only after many periods of unchanged configuration. The stimulus therefore uses a short 7-tick period, so the first overflow arrives at the 12th pulse and a full 32-period window fits in a few hundred clocks. A second run uses a long period with two different non-zero fractions, so that one period can hold a shifted set edge and an unshifted clear edge together, or the reverse.

// File: rtl/pwm_dith_pkg.sv
package pwm_dith_pkg;
  localparam int unsigned FRAC_W   = 5;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned CH_SET   = 0;
  localparam int unsigned CH_CLR   = 1;
  localparam logic [1:0]  POL_HIGH = 2'b10;
endpackage

// File: rtl/pwm_dith_counter.sv
module pwm_dith_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = (cnt_q == mod_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= start_i;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_dith_accum.sv
module pwm_dith_accum
  import pwm_dith_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wrap_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [FRAC_W-1:0] acc_o,
  output logic              ovf_o
);
  logic [FRAC_W-1:0] acc_q;
  logic              ovf_q;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac_i};

  // flag lives for the whole following period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (wrap_i) begin
      acc_q <= sum[FRAC_W-1:0];
      ovf_q <= sum[FRAC_W];
    end
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/pwm_dith_edge.sv
module pwm_dith_edge
  import pwm_dith_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cmp_set_i,
  input  logic [CNT_W-1:0] cmp_clr_i,
  input  logic             dly_set_i,
  input  logic             dly_clr_i,
  input  logic [1:0]       pol_sel_i,
  output logic             pwm_o,
  output logic             pwm_n_o
);
  logic [CNT_W-1:0] eff_set, eff_clr;
  logic             act_q;

  assign eff_set = cmp_set_i + {{(CNT_W-1){1'b0}}, dly_set_i};
  assign eff_clr = cmp_clr_i + {{(CNT_W-1){1'b0}}, dly_clr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 act_q <= 1'b0;
    else if (cnt_i == eff_clr)   act_q <= 1'b0;
    else if (cnt_i == eff_set)   act_q <= 1'b1;
    else if (wrap_i)             act_q <= 1'b0;
  end

  assign pwm_o   = (pol_sel_i == POL_HIGH) ? act_q : ~act_q;
  assign pwm_n_o = ~pwm_o;
endmodule

// File: rtl/pwm_dither_pair.sv
module pwm_dither_pair
  import pwm_dith_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  start_i,
  input  logic [CNT_W-1:0]  mod_i,
  input  logic [CNT_W-1:0]  cmp_set_i,
  input  logic [CNT_W-1:0]  cmp_clr_i,
  input  logic [FRAC_W-1:0] frac_set_i,
  input  logic [FRAC_W-1:0] frac_clr_i,
  input  logic [1:0]        pol_sel_i,
  output logic              pwm_o,
  output logic              pwm_n_o
);
  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic [FRAC_W-1:0] frac [NUM_CH];
  logic [FRAC_W-1:0] acc  [NUM_CH];
  logic [NUM_CH-1:0] ovf;

  assign frac[CH_SET] = frac_set_i;
  assign frac[CH_CLR] = frac_clr_i;

  pwm_dith_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mod_i(mod_i),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwm_dith_accum u_acc (
      .clk_i(clk_i), .rst_ni(rst_ni), .wrap_i(wrap), .frac_i(frac[ch]),
      .acc_o(acc[ch]), .ovf_o(ovf[ch])
    );
  end

  pwm_dith_edge #(.CNT_W(CNT_W)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .wrap_i(wrap),
    .cmp_set_i(cmp_set_i), .cmp_clr_i(cmp_clr_i),
    .dly_set_i(ovf[CH_SET]), .dly_clr_i(ovf[CH_CLR]),
    .pol_sel_i(pol_sel_i), .pwm_o(pwm_o), .pwm_n_o(pwm_n_o)
  );
endmodule

// File: rtl/pwm_dith_checker.sv
module pwm_dith_checker
  import pwm_dith_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  start_i,
  input logic [CNT_W-1:0]  mod_i,
  input logic [FRAC_W-1:0] frac_set_i,
  input logic [FRAC_W-1:0] frac_clr_i,
  input logic [NUM_CH-1:0] ovf,
  input logic              pwm_o,
  input logic              pwm_n_o
);
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != mod_i) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R2
  AST_CNT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == mod_i) |=> (cnt == $past(start_i))); // R2
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != mod_i) |=> $stable(ovf)); // R7
  AST_NO_DITHER_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == mod_i && frac_set_i == '0) |=> !ovf[CH_SET]); // R4
  AST_NO_DITHER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == mod_i && frac_clr_i == '0) |=> !ovf[CH_CLR]); // R4
  AST_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_o != pwm_n_o); // R10
endmodule

bind pwm_dither_pair pwm_dith_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt(cnt), .start_i(start_i), .mod_i(mod_i),
  .frac_set_i(frac_set_i), .frac_clr_i(frac_clr_i), .ovf(ovf),
  .pwm_o(pwm_o), .pwm_n_o(pwm_n_o)
);

// File: tb/tb_pwm_dither_pair.sv
module tb_pwm_dither_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] start, modv, cmp_s, cmp_c;
  logic [4:0]  fr_s, fr_c;
  logic [1:0]  pol;
  logic        pwm, pwm_n;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R7";

  always #10 clk = ~clk;

  pwm_dither_pair dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mod_i(modv),
    .cmp_set_i(cmp_s), .cmp_clr_i(cmp_c), .frac_set_i(fr_s), .frac_clr_i(fr_c),
    .pol_sel_i(pol), .pwm_o(pwm), .pwm_n_o(pwm_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: period bookkeeping with integers
  int m_cnt, m_acc_s, m_acc_c;
  bit m_dly_s, m_dly_c, m_act;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_acc_s = 0; m_acc_c = 0; m_dly_s = 0; m_dly_c = 0; m_act = 0;
    end else begin
      int on_at, off_at;
      on_at  = int'(cmp_s) + int'(m_dly_s);
      off_at = int'(cmp_c) + int'(m_dly_c);
      if (m_cnt == off_at)          m_act = 0;
      else if (m_cnt == on_at)      m_act = 1;
      else if (m_cnt == int'(modv)) m_act = 0;
      if (m_cnt == int'(modv)) begin
        m_acc_s += int'(fr_s); m_dly_s = (m_acc_s >= 32); m_acc_s = m_acc_s % 32;
        m_acc_c += int'(fr_c); m_dly_c = (m_acc_c >= 32); m_acc_c = m_acc_c % 32;
        m_cnt = int'(start);
      end else m_cnt++;
    end
  end

  // per-clock comparison and pulse recording
  int widths[$];
  int rises[$];
  int cyc, run;
  bit prev;
  always @(negedge clk) begin
    if (!rst_n) begin
      widths.delete(); rises.delete(); cyc = 0; run = 0; prev = 0;
    end else begin
      bit lvl, exp_pwm;
      exp_pwm = (pol == 2'b10) ? m_act : ~m_act;
      chk(pwm == exp_pwm, cur_tag, int'(pwm), int'(exp_pwm));
      chk(pwm_n == ~pwm, "R10", int'(pwm_n), int'(~pwm));
      cyc++;
      lvl = (pol == 2'b10) ? pwm : pwm_n;
      if (lvl) run++;
      if (lvl && !prev) rises.push_back(cyc);
      if (!lvl && prev) begin widths.push_back(run); run = 0; end
      prev = lvl;
    end
  end

  task automatic setup(input int s, input int m, input int a, input int b,
                       input int fs, input int fc, input logic [1:0] p, input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    start = 16'(s); modv = 16'(m); cmp_s = 16'(a); cmp_c = 16'(b);
    fr_s = 5'(fs); fr_c = 5'(fc); pol = p; cur_tag = tag;
    repeat (3) @(negedge clk);
    chk(pwm == ~p[1] | p[0], "R1", int'(pwm), int'(~p[1] | p[0]));
    chk(pwm_n == ~pwm, "R1", int'(pwm_n), int'(~pwm));
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwm == ~p[1] | p[0], "R1", int'(pwm), int'(~p[1] | p[0]));
  endtask

  function automatic int sum_win();
    int s = 0;
    for (int i = 1; i <= 32; i++) s += widths[i];
    return s;
  endfunction

  initial begin
    // S1: no dithering
    setup(0, 6, 2, 4, 0, 0, 2'b10, "R3");
    repeat (70) @(negedge clk);
    chk(widths.size() >= 8, "R3", widths.size(), 8);
    for (int i = 0; i < widths.size(); i++) chk(widths[i] == 2, "R3", widths[i], 2);
    for (int i = 1; i < rises.size(); i++)
      chk(rises[i] - rises[i-1] == 7, "R2", rises[i] - rises[i-1], 7);

    // S2: set channel dithers
    setup(0, 6, 2, 4, 3, 0, 2'b10, "R5");
    repeat (260) @(negedge clk);
    chk(widths.size() >= 33, "R4", widths.size(), 33);
    if (widths.size() >= 33) begin
      chk(widths[10] == 2, "R4", widths[10], 2);
      chk(widths[11] == 1, "R5", widths[11], 1);
      chk(widths[12] == 2, "R5", widths[12], 2);
      chk(sum_win() == 61, "R8", sum_win(), 61);
    end

    // S3: clear channel dithers
    setup(0, 6, 2, 4, 0, 3, 2'b10, "R6");
    repeat (260) @(negedge clk);
    chk(widths.size() >= 33, "R6", widths.size(), 33);
    if (widths.size() >= 33) begin
      chk(widths[11] == 3, "R6", widths[11], 3);
      chk(sum_win() == 67, "R8", sum_win(), 67);
    end

    // S4: both dither, non-zero start
    setup(3, 20, 6, 15, 7, 19, 2'b10, "R7");
    repeat (680) @(negedge clk);
    chk(widths.size() >= 33, "R8", widths.size(), 33);
    if (widths.size() >= 33) chk(sum_win() == 300, "R8", sum_win(), 300);

    // S5: low-true polarity
    setup(0, 6, 2, 4, 3, 5, 2'b01, "R9");
    repeat (260) @(negedge clk);
    if (widths.size() >= 33) chk(sum_win() == 66, "R9", sum_win(), 66);
    else chk(0, "R9", widths.size(), 33);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule